// File: doc/BRIEF.md
# Interrupt Request Output Stage

This block drives two request pins toward an external host while the chip runs without its local core: a regular interrupt request and a machine-check request. Both pins are active low and modelled as open drain. When asserted, a pin pulls its line low. When released, the pin stops driving and an external pull-up holds the line high. A per-source routing mask decides whether each source feeds the machine-check pin or the regular pin. Inside each pin's group, the sources are combined by a plain OR.

Sources on the chip travel through short register pipelines. Sources from outside the chip arrive asynchronously, so each one first passes a two-flop synchronizer and then more pipeline stages. Each pin therefore follows its sources with a fixed latency, and that latency is the same for assertion and for release. It depends on which pin the source feeds and on whether the source is internal or external. A mode enable gates both pins. While the enable is low, both pins stay released.

Top module: `irq_out_stage`

## Requirements
- R1: Each pin is modelled as open drain. Its drive-low enable is 1 exactly when its level output is 0. When the pin is released, the enable is 0 and the level output reads 1.
- R2: While `core_dis_en` is 0, both pins are released whatever the sources do. The gate acts in the same cycle the enable changes.
- R3: An internal source routed to the regular pin asserts that pin 3 clock edges after the source rises.
- R4: The regular pin releases 3 clock edges after its last active internal source falls.
- R5: An internal source routed to the machine-check pin asserts that pin 2 clock edges after it rises, and releases it 2 edges after it falls.
- R6: An external source routed to the regular pin asserts it 4 edges after it rises, and releases it 4 edges after it falls. The synchronizer is included in these 4 edges.
- R7: An external source routed to the machine-check pin asserts it 4 edges after it rises, and releases it 4 edges after it falls.
- R8: Bit i of `mck_route_int` (or of `mck_route_ext`) set to 1 sends source i to the machine-check pin. Set to 0, it sends source i to the regular pin. A source never reaches both pins.
- R9: A pin stays asserted while at least one source routed to it is still active once its latency has passed. It releases only when none is active.
- R10: Reset releases both pins at once and clears every pipeline stage. A source that was active before reset reappears only after the full latency, counted from the release of reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| core_dis_en | input | 1 | Enables driving of both request pins |
| int_src | input | N_INT | On-chip interrupt sources, active high, synchronous |
| ext_src | input | N_EXT | Off-chip interrupt sources, active high, asynchronous |
| mck_route_int | input | N_INT | Per internal source: 1 = machine-check pin, 0 = regular pin |
| mck_route_ext | input | N_EXT | Per external source: 1 = machine-check pin, 0 = regular pin |
| irq_drv_low | output | 1 | Regular pin pull-down enable |
| irq_n | output | 1 | Regular pin line level (pull-up assumed) |
| mck_drv_low | output | 1 | Machine-check pin pull-down enable |
| mck_n | output | 1 | Machine-check pin line level (pull-up assumed) |

## Verification
The bench places its checks one edge before and exactly at each latency boundary, for both edges of each of the four source/pin pairs. A pipeline one stage too short or too long, or a release path that skips stages, shows up as a pin that changes a cycle early or late. It also checks the highest-numbered sources, the routing mask in both directions, and an overlap where one source falls while another holds the pin. A swapped mask or an AND in place of the OR would drop or misdirect the request in those cases. It also resets the block with a source active. A pipeline that kept its contents through reset would then assert the pin too early.

// File: rtl/irq_os_pkg.sv
package irq_os_pkg;

  // One routed request pair: regular pin and machine-check pin
  typedef struct packed {
    logic regular;
    logic mck;
  } req_pair_t;

  // Split a source vector by the routing mask and OR each group
  function automatic req_pair_t route_or(input logic [63:0] src,
                                         input logic [63:0] sel,
                                         input int unsigned width);
    req_pair_t r;
    r.regular = 1'b0;
    r.mck     = 1'b0;
    for (int i = 0; i < 64; i++) begin
      if (i < int'(width)) begin
        r.regular = r.regular | (src[i] & ~sel[i]);
        r.mck     = r.mck     | (src[i] &  sel[i]);
      end
    end
    return r;
  endfunction

  // Line level of an open-drain pin with an external pull-up
  function automatic logic od_level(input logic drive_low);
    return drive_low ? 1'b0 : 1'b1;
  endfunction

endpackage

// File: rtl/irq_os_sync.sv
module irq_os_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/irq_os_delay.sv
module irq_os_delay #(
  parameter int DEPTH = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  generate
    if (DEPTH == 0) begin : g_pass
      assign q = d;
    end else begin : g_pipe
      logic [DEPTH-1:0] sr;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          sr <= '0;
        end else begin
          sr[0] <= d;
          for (int i = 1; i < DEPTH; i++) sr[i] <= sr[i-1];
        end
      end
      assign q = sr[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/irq_os_split.sv
module irq_os_split
  import irq_os_pkg::*;
#(
  parameter int WIDTH = 16
) (
  input  logic [WIDTH-1:0] src,
  input  logic [WIDTH-1:0] mck_sel,
  output req_pair_t        req
);
  logic [63:0] src_w;
  logic [63:0] sel_w;

  always_comb begin
    src_w = '0;
    sel_w = '0;
    src_w[WIDTH-1:0] = src;
    sel_w[WIDTH-1:0] = mck_sel;
    req = route_or(src_w, sel_w, WIDTH);
  end
endmodule

// File: rtl/irq_os_pin.sv
module irq_os_pin
  import irq_os_pkg::*;
(
  input  logic enable,
  input  logic request,
  output logic drv_low,
  output logic level
);
  assign drv_low = enable & request;
  assign level   = od_level(drv_low);
endmodule

// File: rtl/irq_out_stage.sv
module irq_out_stage
  import irq_os_pkg::*;
#(
  parameter int N_INT       = 16,
  parameter int N_EXT       = 4,
  parameter int LAT_INT_IRQ = 3,
  parameter int LAT_INT_MCK = 2,
  parameter int LAT_EXT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             core_dis_en,
  input  logic [N_INT-1:0] int_src,
  input  logic [N_EXT-1:0] ext_src,
  input  logic [N_INT-1:0] mck_route_int,
  input  logic [N_EXT-1:0] mck_route_ext,
  output logic             irq_drv_low,
  output logic             irq_n,
  output logic             mck_drv_low,
  output logic             mck_n
);
  localparam int EXT_TAIL = LAT_EXT - SYNC_STAGES;

  // Named internal events, also watched by the checker
  logic [N_EXT-1:0] ext_synced;
  req_pair_t        int_req;
  req_pair_t        ext_req;
  logic             irq_int_dly;
  logic             mck_int_dly;
  logic             irq_ext_dly;
  logic             mck_ext_dly;
  logic             irq_req_any;
  logic             mck_req_any;

  irq_os_sync #(.WIDTH(N_EXT), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_src), .q(ext_synced)
  );

  irq_os_split #(.WIDTH(N_INT)) u_split_int (
    .src(int_src), .mck_sel(mck_route_int), .req(int_req)
  );

  irq_os_split #(.WIDTH(N_EXT)) u_split_ext (
    .src(ext_synced), .mck_sel(mck_route_ext), .req(ext_req)
  );

  irq_os_delay #(.DEPTH(LAT_INT_IRQ)) u_dly_int_irq (
    .clk(clk), .rst_n(rst_n), .d(int_req.regular), .q(irq_int_dly)
  );

  irq_os_delay #(.DEPTH(LAT_INT_MCK)) u_dly_int_mck (
    .clk(clk), .rst_n(rst_n), .d(int_req.mck), .q(mck_int_dly)
  );

  irq_os_delay #(.DEPTH(EXT_TAIL)) u_dly_ext_irq (
    .clk(clk), .rst_n(rst_n), .d(ext_req.regular), .q(irq_ext_dly)
  );

  irq_os_delay #(.DEPTH(EXT_TAIL)) u_dly_ext_mck (
    .clk(clk), .rst_n(rst_n), .d(ext_req.mck), .q(mck_ext_dly)
  );

  assign irq_req_any = irq_int_dly | irq_ext_dly;
  assign mck_req_any = mck_int_dly | mck_ext_dly;

  irq_os_pin u_pin_irq (
    .enable(core_dis_en), .request(irq_req_any),
    .drv_low(irq_drv_low), .level(irq_n)
  );

  irq_os_pin u_pin_mck (
    .enable(core_dis_en), .request(mck_req_any),
    .drv_low(mck_drv_low), .level(mck_n)
  );
endmodule

// File: rtl/irq_os_chk.sv
module irq_os_chk #(
  parameter int N_INT       = 16,
  parameter int N_EXT       = 4,
  parameter int LAT_INT_IRQ = 3,
  parameter int LAT_INT_MCK = 2,
  parameter int LAT_EXT     = 4,
  parameter int SYNC_STAGES = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             core_dis_en,
  input logic [N_INT-1:0] int_src,
  input logic [N_EXT-1:0] ext_src,
  input logic [N_INT-1:0] mck_route_int,
  input logic [N_EXT-1:0] mck_route_ext,
  input logic             irq_int_dly,
  input logic             mck_int_dly,
  input logic             irq_ext_dly,
  input logic             mck_ext_dly,
  input logic             irq_drv_low,
  input logic             mck_drv_low,
  input logic             irq_n,
  input logic             mck_n
);
  localparam int EXT_TAIL = LAT_EXT - SYNC_STAGES;
  localparam int INT_MAX  = (LAT_INT_IRQ > LAT_INT_MCK) ? LAT_INT_IRQ : LAT_INT_MCK;

  // Histories of the raw inputs, index k = value k edges ago
  logic [N_INT-1:0] is_h [1:INT_MAX];
  logic [N_INT-1:0] ir_h [1:INT_MAX];
  logic [N_EXT-1:0] es_h [1:LAT_EXT];
  logic [N_EXT-1:0] er_h [1:LAT_EXT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 1; k <= INT_MAX; k++) begin
        is_h[k] <= '0;
        ir_h[k] <= '0;
      end
      for (int k = 1; k <= LAT_EXT; k++) begin
        es_h[k] <= '0;
        er_h[k] <= '0;
      end
    end else begin
      is_h[1] <= int_src;
      ir_h[1] <= mck_route_int;
      for (int k = 2; k <= INT_MAX; k++) begin
        is_h[k] <= is_h[k-1];
        ir_h[k] <= ir_h[k-1];
      end
      es_h[1] <= ext_src;
      er_h[1] <= mck_route_ext;
      for (int k = 2; k <= LAT_EXT; k++) begin
        es_h[k] <= es_h[k-1];
        er_h[k] <= er_h[k-1];
      end
    end
  end

  logic [N_EXT-1:0] ext_rt_at_tail;
  generate
    if (EXT_TAIL == 0) begin : g_rt_now
      assign ext_rt_at_tail = mck_route_ext;
    end else begin : g_rt_past
      assign ext_rt_at_tail = er_h[EXT_TAIL];
    end
  endgenerate

  logic exp_irq_int, exp_mck_int, exp_irq_ext, exp_mck_ext;
  assign exp_irq_int = |(is_h[LAT_INT_IRQ] & ~ir_h[LAT_INT_IRQ]);
  assign exp_mck_int = |(is_h[LAT_INT_MCK] &  ir_h[LAT_INT_MCK]);
  assign exp_irq_ext = |(es_h[LAT_EXT] & ~ext_rt_at_tail);
  assign exp_mck_ext = |(es_h[LAT_EXT] &  ext_rt_at_tail);

  AST_INT_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_int_dly == exp_irq_int); // R3
  AST_INT_MCK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mck_int_dly == exp_mck_int); // R5
  AST_EXT_IRQ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    irq_ext_dly == exp_irq_ext); // R6
  AST_EXT_MCK_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    mck_ext_dly == exp_mck_ext); // R7
  AST_MODE_OFF_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    !core_dis_en |-> (!irq_drv_low && !mck_drv_low && irq_n && mck_n)); // R2
  AST_ANY_PATH_ASSERTS: assert property (@(posedge clk) disable iff (!rst_n)
    (core_dis_en && (irq_int_dly || irq_ext_dly)) |-> !irq_n); // R9
  AST_NO_PATH_RELEASES: assert property (@(posedge clk) disable iff (!rst_n)
    (!mck_int_dly && !mck_ext_dly) |-> mck_n); // R9
endmodule

bind irq_out_stage irq_os_chk #(
  .N_INT(N_INT), .N_EXT(N_EXT), .LAT_INT_IRQ(LAT_INT_IRQ),
  .LAT_INT_MCK(LAT_INT_MCK), .LAT_EXT(LAT_EXT), .SYNC_STAGES(SYNC_STAGES)
) u_chk (
  .clk(clk), .rst_n(rst_n), .core_dis_en(core_dis_en),
  .int_src(int_src), .ext_src(ext_src),
  .mck_route_int(mck_route_int), .mck_route_ext(mck_route_ext),
  .irq_int_dly(irq_int_dly), .mck_int_dly(mck_int_dly),
  .irq_ext_dly(irq_ext_dly), .mck_ext_dly(mck_ext_dly),
  .irq_drv_low(irq_drv_low), .mck_drv_low(mck_drv_low),
  .irq_n(irq_n), .mck_n(mck_n)
);

// File: tb/tb_irq_out_stage.sv
`timescale 1ns/1ps
module tb_irq_out_stage;
  localparam int NI = 16;
  localparam int NE = 4;
  // Latencies taken from the requirements
  localparam int L_INT_IRQ = 3;
  localparam int L_INT_MCK = 2;
  localparam int L_EXT     = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          core_dis_en = 1'b0;
  logic [NI-1:0] int_src = '0;
  logic [NE-1:0] ext_src = '0;
  logic [NI-1:0] mck_route_int = '0;
  logic [NE-1:0] mck_route_ext = '0;
  logic irq_drv_low, irq_n, mck_drv_low, mck_n;

  int tests = 0;
  int fails = 0;

  always #4 clk = ~clk;

  irq_out_stage dut (
    .clk(clk), .rst_n(rst_n), .core_dis_en(core_dis_en),
    .int_src(int_src), .ext_src(ext_src),
    .mck_route_int(mck_route_int), .mck_route_ext(mck_route_ext),
    .irq_drv_low(irq_drv_low), .irq_n(irq_n),
    .mck_drv_low(mck_drv_low), .mck_n(mck_n)
  );

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  // exp = {irq asserted, mck asserted}; also checks open-drain consistency (R1)
  task automatic chk(input string tag, input logic [1:0] exp);
    logic [1:0] got;
    got = {~irq_n, ~mck_n};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: asserted {irq,mck} got %b expected %b", tag, got, exp);
    end
    tests++;
    if ({irq_drv_low, mck_drv_low} !== exp) begin
      fails++;
      $display("FAIL R1 (%s): drive_low {irq,mck} got %b expected %b",
               tag, {irq_drv_low, mck_drv_low}, exp);
    end
  endtask

  task automatic quiet();
    int_src = '0;
    ext_src = '0;
    wait_n(6);
  endtask

  // Pulse one source and check both edges one cycle before and at the latency
  task automatic lat_case(input string tag, input bit is_ext, input int idx,
                          input bit to_mck, input int lat);
    logic [1:0] on;
    on = to_mck ? 2'b01 : 2'b10;
    if (is_ext) ext_src[idx] = 1'b1; else int_src[idx] = 1'b1;
    wait_n(lat - 1);
    chk({tag, " rise early"}, 2'b00);
    wait_n(1);
    chk({tag, " rise"}, on);
    if (is_ext) ext_src[idx] = 1'b0; else int_src[idx] = 1'b0;
    wait_n(lat - 1);
    chk({tag, " fall early"}, on);
    wait_n(1);
    chk({tag, " fall"}, 2'b00);
    wait_n(3);
  endtask

  task automatic t_reset();
    wait_n(1);
    chk("R10 in reset", 2'b00);
    rst_n = 1'b1;
    wait_n(2);
    chk("R10 after reset", 2'b00);
  endtask

  task automatic t_internal();
    core_dis_en = 1'b1;
    mck_route_int = 16'h0020;
    lat_case("R3 R4 int0 regular", 1'b0, 0, 1'b0, L_INT_IRQ);
    lat_case("R3 R4 int15 regular", 1'b0, 15, 1'b0, L_INT_IRQ);
    lat_case("R5 R8 int5 mck", 1'b0, 5, 1'b1, L_INT_MCK);
    quiet();
  endtask

  task automatic t_external();
    mck_route_ext = 4'b1000;
    lat_case("R6 ext0 regular", 1'b1, 0, 1'b0, L_EXT);
    lat_case("R7 R8 ext3 mck", 1'b1, 3, 1'b1, L_EXT);
    quiet();
  endtask

  task automatic t_mode_off();
    core_dis_en = 1'b0;
    int_src[0] = 1'b1;
    int_src[5] = 1'b1;
    ext_src[3] = 1'b1;
    wait_n(6);
    chk("R2 mode off with sources", 2'b00);
    core_dis_en = 1'b1;
    #1;
    chk("R2 mode on same cycle", 2'b11);
    wait_n(1);
    core_dis_en = 1'b0;
    #1;
    chk("R2 mode off same cycle", 2'b00);
    core_dis_en = 1'b1;
    quiet();
  endtask

  task automatic t_overlap();
    int_src[2] = 1'b1;
    int_src[7] = 1'b1;
    wait_n(L_INT_IRQ);
    chk("R9 two sources", 2'b10);
    int_src[2] = 1'b0;
    wait_n(L_INT_IRQ + 1);
    chk("R9 one remains", 2'b10);
    int_src[7] = 1'b0;
    wait_n(L_INT_IRQ);
    chk("R9 none remains", 2'b00);
    quiet();
  endtask

  task automatic t_route_mix();
    mck_route_int = 16'h0010;
    mck_route_ext = 4'b0000;
    int_src[4] = 1'b1;
    ext_src[1] = 1'b1;
    wait_n(L_EXT);
    chk("R8 int4 mck, ext1 regular", 2'b11);
    int_src[4] = 1'b0;
    wait_n(L_EXT);
    chk("R8 ext1 only regular", 2'b10);
    mck_route_ext = 4'b0010;
    wait_n(L_EXT);
    chk("R8 ext1 rerouted to mck", 2'b01);
    quiet();
    mck_route_int = '0;
    mck_route_ext = '0;
  endtask

  task automatic t_reset_flush();
    int_src[0] = 1'b1;
    wait_n(L_INT_IRQ + 1);
    chk("R10 pre-reset active", 2'b10);
    rst_n = 1'b0;
    #1;
    chk("R10 reset releases at once", 2'b00);
    wait_n(1);
    rst_n = 1'b1;
    wait_n(L_INT_IRQ - 1);
    chk("R10 pipeline cleared", 2'b00);
    wait_n(1);
    chk("R10 refilled after latency", 2'b10);
    quiet();
  endtask

  task automatic summary();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
  endtask

  initial begin
    wait_n(2);
    t_reset();
    t_internal();
    t_external();
    t_mode_off();
    t_overlap();
    t_route_mix();
    t_reset_flush();
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not complete");
    summary();
    $finish;
  end
endmodule